// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with One Compare Channel

A register-mapped timer for a system bus. An up-counter steps on a prescaled tick. Its width is chosen at build time as 16 or 32 bits. The counter climbs from zero to a programmable wrap limit, returns to zero and raises an overflow flag as it does so. One compare channel watches the counter. When the channel is in software-compare mode, it raises a flag at the moment the counter steps onto the programmed compare value. That flag drives an interrupt line when the channel's interrupt enable is set.

Software reaches the block through a flat 32-bit register port: a byte address, a write strobe, write data, and read data that is decoded combinationally. Both status flags are cleared only by writing a one to them. The compare flag can be read and cleared in two places: the global status word and the channel control word.

Top module: `tmr_cmp`

## Requirements
- R1: Reading byte offset 0x04 returns the counter width in bits 23:16 (0x20 for 32-bit, 0x10 for 16-bit) and zero elsewhere; writes there change nothing.
- R2: After reset the counter, control, channel and status registers read zero, the wrap limit at 0x18 reads all ones at the counter width, and the irq output is low.
- R3: The counter advances only while bits 4:3 of the control word at 0x10 hold 01; any other value holds it still.
- R4: Bits 2:0 of the control word (N) set the step rate to one step every 2^N clocks, with the first step 2^N clocks after counting starts.
- R5: On a step with the counter equal to the wrap limit (0x18), the counter goes to zero and bit 7 of the control word (overflow flag) is set.
- R6: The overflow flag clears only when bit 7 is written as one to 0x10; a write with bit 7 at zero leaves it set.
- R7: Any write to the counter at 0x14 makes it zero and restarts the prescale phase; the written value is never stored.
- R8: With channel mode (bits 5:2 of 0x20) equal to 0x4, a step that lands the counter on the compare value (0x24) sets the channel flag; other modes never set it, and a counter that stays on the compare value without stepping does not set it again.
- R9: The channel flag reads at bit 0 of 0x1C and bit 7 of 0x20; writing one to either bit clears it, and writing zero leaves it set.
- R10: irq is high exactly while the channel flag is set and the channel interrupt enable (bit 6 of 0x20) is one.
- R11: Register bits that have no function read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Channel interrupt request |

## Verification
A register write takes effect on the clock edge that samples it, so the bench reads back half a cycle later; rdata and irq are combinational from the registers. The count is deterministic. Once a start write lands, the edges that follow are numbered 1, 2 and so on, and a step happens on each edge whose number is a multiple of 2^N. The edge that captures the stop write still counts. The bench therefore predicts counts as floor(edges / 2^N) and reads them only after the counter is stopped. The compare and overflow flags are set on the same edge as the step that causes them, and each is checked after a stop, against the count computed for that stop.

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int DIV_W = (1 << PSC_W) - 1;
  localparam logic [7:0] A_PARAM = 8'h04, A_CTRL = 8'h10, A_CNT = 8'h14,
                         A_MOD = 8'h18, A_STAT = 8'h1C, A_CHC = 8'h20, A_CMP = 8'h24;

  logic [CNT_W-1:0] cnt_q, mod_q, cmp_q, cnt_nxt;
  logic [1:0]       clk_mode_q;
  logic [PSC_W-1:0] psc_q;
  logic [DIV_W-1:0] div_q, div_mask;
  logic             ovf_q, chie_q, chf_q;
  logic [3:0]       chmode_q;
  logic             run, tick, wrap, hit, cnt_wr;

  assign cnt_wr   = wr_en && addr == A_CNT;
  assign run      = clk_mode_q == 2'b01;
  assign div_mask = (DIV_W'(1) << psc_q) - DIV_W'(1);
  assign tick     = run && ((div_q & div_mask) == div_mask) && !cnt_wr;
  assign wrap     = cnt_q == mod_q;
  assign cnt_nxt  = wrap ? '0 : cnt_q + CNT_W'(1);
  assign hit      = tick && chmode_q == 4'h4 && cnt_nxt == cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; div_q <= '0; mod_q <= '1; cmp_q <= '0;
      clk_mode_q <= '0; psc_q <= '0; ovf_q <= 1'b0;
      chmode_q <= '0; chie_q <= 1'b0; chf_q <= 1'b0;
    end else begin
      div_q <= (!run || cnt_wr) ? '0 : div_q + DIV_W'(1);
      if (cnt_wr)    cnt_q <= '0;
      else if (tick) cnt_q <= cnt_nxt;

      if (wr_en && addr == A_CTRL) begin
        clk_mode_q <= wdata[4:3];
        psc_q      <= wdata[PSC_W-1:0];
      end
      if (wr_en && addr == A_MOD) mod_q <= wdata[CNT_W-1:0];
      if (wr_en && addr == A_CMP) cmp_q <= wdata[CNT_W-1:0];
      if (wr_en && addr == A_CHC) begin
        chmode_q <= wdata[5:2];
        chie_q   <= wdata[6];
      end

      if (tick && wrap)                             ovf_q <= 1'b1;
      else if (wr_en && addr == A_CTRL && wdata[7]) ovf_q <= 1'b0;

      if (hit)                                           chf_q <= 1'b1;
      else if (wr_en && ((addr == A_STAT && wdata[0]) ||
                         (addr == A_CHC  && wdata[7])))  chf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_PARAM: rdata[23:16] = 8'(CNT_W);
      A_CTRL:  rdata = {24'd0, ovf_q, 2'b00, clk_mode_q, 3'(psc_q)};
      A_CNT:   rdata = 32'(cnt_q);
      A_MOD:   rdata = 32'(mod_q);
      A_STAT:  rdata = {31'd0, chf_q};
      A_CHC:   rdata = {24'd0, chf_q, chie_q, chmode_q, 2'b00};
      A_CMP:   rdata = 32'(cmp_q);
      default: rdata = '0;
    endcase
  end

  assign irq = chf_q & chie_q;
endmodule

module tmr_cmp_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       addr,
  input logic             wr_en,
  input logic [31:0]      wdata,
  input logic             irq,
  input logic             tick,
  input logic [1:0]       clk_mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] mod_q,
  input logic             ovf_q,
  input logic             chf_q,
  input logic             chie_q
);
  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == mod_q) |=> (cnt_q == '0 && ovf_q));

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_mode_q != 2'b01 && !(wr_en && addr == 8'h14)) |=> $stable(cnt_q));

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h14) |=> cnt_q == '0);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(wr_en && addr == 8'h10 && wdata[7])) |=> ovf_q);

  a_r8_flag_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chf_q) |-> $past(tick));

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (chf_q && chie_q));
endmodule

bind tmr_cmp tmr_cmp_chk #(.CNT_W(CNT_W)) u_tmr_cmp_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .irq(irq), .tick(tick), .clk_mode_q(clk_mode_q), .cnt_q(cnt_q),
  .mod_q(mod_q), .ovf_q(ovf_q), .chf_q(chf_q), .chie_q(chie_q)
);

// File: tb/test_tmr_cmp.sv
module test_tmr_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  addr16 = 8'h04;
  logic [31:0] rdata16;
  logic        irq16;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tmr_cmp i_tmr_cmp (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                     .wdata(wdata), .rdata(rdata), .irq(irq));
  tmr_cmp #(.CNT_W(16)) i_tmr_cmp16 (.clk(clk), .rst_n(rst_n), .addr(addr16),
                     .wr_en(1'b0), .wdata(32'd0), .rdata(rdata16), .irq(irq16));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // count for 'edges' clock edges with prescale n, then stop
  task automatic run(input int n, input int edges);
    wr(8'h10, 32'h08 | n);
    for (int i = 1; i < edges; i++) @(negedge clk);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_reset;
    chk_reg("R1 width 32", 8'h04, 32'h0020_0000);
    addr16 = 8'h04; #1; chk("R1 width 16", rdata16, 32'h0010_0000);
    addr16 = 8'h18; #1; chk("R2 mod16 reset", rdata16, 32'h0000_FFFF);
    chk_reg("R2 ctrl", 8'h10, 0);
    chk_reg("R2 cnt", 8'h14, 0);
    chk_reg("R2 mod", 8'h18, 32'hFFFF_FFFF);
    chk_reg("R2 stat", 8'h1C, 0);
    chk_reg("R2 chc", 8'h20, 0);
    chk("R2 irq", irq, 0);
  endtask

  task automatic t_prescale;
    run(0, 20);  chk_reg("R4 div1", 8'h14, 20);
    wr(8'h14, 32'h1234); chk_reg("R7 clear", 8'h14, 0);
    run(3, 40);  chk_reg("R4 div8", 8'h14, 5);
    wr(8'h14, 0);
    run(7, 256); chk_reg("R4 div128", 8'h14, 2);
    wr(8'h14, 0);
    wr(8'h10, 32'h10);
    repeat (10) @(negedge clk);
    chk_reg("R3 mode 10 holds", 8'h14, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    chk_reg("R11 ctrl unused bits", 8'h10, 32'h1F);
    repeat (10) @(negedge clk);
    chk_reg("R3 mode 11 holds", 8'h14, 0);
    wr(8'h10, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    chk_reg("R1 param read-only", 8'h04, 32'h0020_0000);
  endtask

  task automatic t_wrap;
    wr(8'h14, 0); wr(8'h18, 4);
    run(0, 4); chk_reg("R5 before wrap", 8'h10, 0);
    run(0, 1); chk_reg("R5 wrapped cnt", 8'h14, 0);
    chk_reg("R5 ovf set", 8'h10, 32'h80);
    wr(8'h10, 32'h00); chk_reg("R6 write0 keeps", 8'h10, 32'h80);
    wr(8'h10, 32'h80); chk_reg("R6 write1 clears", 8'h10, 0);
    wr(8'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_compare;
    wr(8'h14, 0); wr(8'h24, 10); wr(8'h20, 32'h50);
    run(0, 9);
    chk_reg("R8 no early flag", 8'h1C, 0); chk("R10 irq low", irq, 0);
    run(0, 3);
    chk_reg("R8 cnt", 8'h14, 12);
    chk_reg("R9 stat flag", 8'h1C, 1);
    chk_reg("R9 chc flag", 8'h20, 32'hD0);
    chk("R10 irq high", irq, 1);
    wr(8'h1C, 0); chk_reg("R9 write0 keeps", 8'h1C, 1);
    wr(8'h1C, 1); chk_reg("R9 stat clear", 8'h20, 32'h50);
    chk("R10 irq cleared", irq, 0);
    wr(8'h14, 0); run(0, 12);
    wr(8'h20, 32'hD0); chk_reg("R9 chc clear", 8'h1C, 0);
    wr(8'h20, 32'h10); wr(8'h14, 0); run(0, 12);
    chk_reg("R10 flag no ie", 8'h1C, 1); chk("R10 irq masked", irq, 0);
    wr(8'h20, 32'h80); wr(8'h14, 0); run(0, 12);
    chk_reg("R8 mode off no flag", 8'h1C, 0);
  endtask

  task automatic t_no_retrigger;
    wr(8'h14, 0); wr(8'h24, 1); wr(8'h20, 32'h50);
    run(3, 10);
    chk_reg("R8 slow match cnt", 8'h14, 1);
    chk_reg("R8 slow match flag", 8'h1C, 1);
    wr(8'h1C, 1);
    run(3, 4);
    chk_reg("R8 dwell cnt", 8'h14, 1);
    chk_reg("R8 dwell no reflag", 8'h1C, 0);
  endtask

  logic done = 1'b0;
  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_prescale;
    t_wrap;
    t_compare;
    t_no_retrigger;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule